// File: doc/BRIEF.md
# Inductor Current Ramp Estimator

This block rebuilds the inductor current ramp of a buck converter from voltage samples alone, so that a digital valley-type V2 loop can use it as an internal ramp in place of a sensed current or a fixed external ramp. Each system clock it adds a slope to a saturating accumulator. While the power switch is on, the slope is proportional to the input minus the output voltage. While the switch is off, it is proportional to minus the output voltage. The gain is programmable and stands for the clock period divided by the inductance. The input voltage may come from a slow converter, so the block keeps its last valid code between updates.

In steady state, rounding and gain mismatch would let the estimate wander. At every switch turn-on, which is the valley of the ramp, a correction pulls the estimate toward a preset valley level. The correction is a right-shifted fraction of the error between that level and the estimate. The block adds the estimate to the output-voltage code to form the modulation signal. When that sum drops below a reference, it raises a one-clock request for the pulse-width modulator to start a new on-time.

Top module: `cur_ramp_est`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator is loaded with `valley_ref` placed in its upper 16 bits with 8 zero fraction bits. After that edge, `ramp_est` equals `valley_ref` and `valley_trig` is 0.
- R2: The input-voltage code is registered only on an edge where `vin_valid` is 1. The on-time slope uses this held code until the next valid sample, whatever `vin_code` carries in between.
- R3: On an edge where `sw_on` is 1, the 24-bit signed accumulator gains (k_gain × (vin_held − vout_code)) >>> 8. The shift is arithmetic, `k_gain` is signed, and both voltage codes are unsigned.
- R4: On an edge where `sw_on` is 0, the accumulator gains (k_gain × (−vout_code)) >>> 8, so with non-negative gain the estimate never rises during the off-time.
- R5: On an edge where `sw_on` is 1 and was 0 on the previous edge, the accumulator also gains ((valley_ref·256) − acc) >>> `drift_shift`, using the pre-edge accumulator value. With a shift of 0, the estimate lands exactly on the preset valley plus that edge's slope.
- R6: The accumulator saturates at +8388607 and −8388608 and never wraps. Once it is pinned, further slope in the same direction leaves it pinned.
- R7: `ramp_est` is the upper 16 bits of the accumulator, which is the accumulator arithmetically shifted right by 8.
- R8: Let m = vout_code + ramp_est (signed), evaluated with the values before an edge. `valley_trig` is 1 for exactly one clock after the first edge at which m < `trig_ref`. It stays 0 while m remains below the reference.
- R9: After reset, no trigger is issued until m has been at or above `trig_ref` at some edge, even if m starts out below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_on | input | 1 | Power switch state from the pulse-width modulator, 1 = on |
| vin_valid | input | 1 | Strobe marking a fresh input-voltage code |
| vin_code | input | 12 | Input-voltage code, unsigned |
| vout_code | input | 12 | Output-voltage code, unsigned |
| k_gain | input | 16 | Signed slope gain (clock period over inductance) |
| drift_shift | input | 5 | Right shift applied to the valley error |
| valley_ref | input | 16 | Signed preset valley level, in ramp_est units |
| trig_ref | input | 18 | Signed threshold for the modulation signal |
| ramp_est | output | 16 | Signed current-ramp estimate |
| valley_trig | output | 1 | One-clock request for a new on-time |

## Verification
The bench drives the accumulator into both saturation rails with the largest gain and voltage span. A design that wraps would show the estimate jumping to the opposite sign. The bench changes `vin_code` without a strobe during an on-time, which exposes any design that uses the live code instead of the held one. It runs off-to-on transitions with shifts of 0 and 2, which catches a correction applied every cycle, on the wrong edge, or with the post-edge value. A reset taken with the modulation signal already below its threshold, followed by a held crossing, shows whether the trigger is armed too early or repeats instead of pulsing once.

// File: rtl/cre_pkg.sv
package cre_pkg;

    // Switching phase seen by the slope and correction logic
    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_VALLEY = 2'd1,
        PH_ON     = 2'd2
    } phase_e;

endpackage

// File: rtl/cre_vin_hold.sv
module cre_vin_hold #(
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vin_valid,
    input  logic [VW-1:0] vin_code,
    output logic [VW-1:0] vin_held
);

    typedef struct packed {
        logic [VW-1:0] vin;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vin_valid) begin
            st_d.vin = vin_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vin_held = st_q.vin;

    AST_VIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!vin_valid) |=> $stable(vin_held)); // R2

endmodule

// File: rtl/cre_slope_gen.sv
module cre_slope_gen
    import cre_pkg::*;
#(
    parameter int VW       = 12,
    parameter int KW       = 16,
    parameter int SLOPE_SH = 8,
    parameter int SUM_W    = 31
) (
    input  logic                    [VW-1:0]    vin_held,
    input  logic                    [VW-1:0]    vout_code,
    input  logic signed             [KW-1:0]    k_gain,
    input  phase_e                              phase,
    output logic signed             [SUM_W-1:0] slope
);

    localparam int DW     = VW + 1;
    localparam int PROD_W = KW + DW;

    logic signed [DW-1:0]     dv;
    logic signed [PROD_W-1:0] k_ext;
    logic signed [PROD_W-1:0] dv_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] prod_sh;

    always_comb begin
        // voltage across the inductor, in input code units
        if (phase == PH_OFF) begin
            dv = -$signed({1'b0, vout_code});
        end else begin
            dv = $signed({1'b0, vin_held}) - $signed({1'b0, vout_code});
        end
        k_ext   = {{(PROD_W-KW){k_gain[KW-1]}}, k_gain};
        dv_ext  = {{(PROD_W-DW){dv[DW-1]}}, dv};
        prod    = k_ext * dv_ext;
        prod_sh = prod >>> SLOPE_SH;
    end

    generate
        if (SUM_W > PROD_W) begin : g_ext
            assign slope = {{(SUM_W-PROD_W){prod_sh[PROD_W-1]}}, prod_sh};
        end else begin : g_same
            assign slope = prod_sh[SUM_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/cre_accum.sv
module cre_accum
    import cre_pkg::*;
#(
    parameter int ACC_W = 24,
    parameter int OUT_W = 16,
    parameter int SUM_W = 31,
    parameter int SHW   = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sw_on,
    input  logic signed [SUM_W-1:0] slope,
    input  logic signed [OUT_W-1:0] valley_ref,
    input  logic        [SHW-1:0]   drift_shift,
    output phase_e                  phase,
    output logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] ramp_est
);

    localparam int FRAC  = ACC_W - OUT_W;
    localparam int ERR_W = ACC_W + 1;
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] SUM_MAX = {{(SUM_W-ACC_W){1'b0}}, ACC_MAX};
    localparam logic signed [SUM_W-1:0] SUM_MIN = {{(SUM_W-ACC_W){1'b1}}, ACC_MIN};

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic                    sw;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic signed [ACC_W-1:0] ref_full;
    logic signed [ERR_W-1:0] err;
    logic signed [ERR_W-1:0] corr;
    logic signed [SUM_W-1:0] sum;

    // valley is the first on-clock after an off period
    always_comb begin
        if (sw_on && !st_q.sw) begin
            phase = PH_VALLEY;
        end else if (sw_on) begin
            phase = PH_ON;
        end else begin
            phase = PH_OFF;
        end
    end

    always_comb begin
        ref_full = {valley_ref, {FRAC{1'b0}}};
        err  = {ref_full[ACC_W-1], ref_full} - {st_q.acc[ACC_W-1], st_q.acc};
        corr = (phase == PH_VALLEY) ? (err >>> drift_shift) : '0;
        sum  = {{(SUM_W-ACC_W){st_q.acc[ACC_W-1]}}, st_q.acc}
             + slope
             + {{(SUM_W-ERR_W){corr[ERR_W-1]}}, corr};

        st_d    = st_q;
        st_d.sw = sw_on;
        if (sum > SUM_MAX) begin
            st_d.acc = ACC_MAX;
        end else if (sum < SUM_MIN) begin
            st_d.acc = ACC_MIN;
        end else begin
            st_d.acc = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.acc <= {valley_ref, {FRAC{1'b0}}};
            st_q.sw  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc      = st_q.acc;
    assign ramp_est = st_q.acc[ACC_W-1 -: OUT_W];

    AST_RESET_LOAD: assert property (@(posedge clk)
        rst |=> (ramp_est == $past(valley_ref))); // R1

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_MAX && phase == PH_ON && !slope[SUM_W-1]) |=> (acc == ACC_MAX)); // R6

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_MIN && phase == PH_OFF && slope[SUM_W-1]) |=> (acc == ACC_MIN)); // R6

endmodule

// File: rtl/cre_valley_cmp.sv
module cre_valley_cmp #(
    parameter int VW    = 12,
    parameter int OUT_W = 16,
    parameter int MW    = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic        [VW-1:0]    vout_code,
    input  logic signed [OUT_W-1:0] ramp_est,
    input  logic signed [MW-1:0]    trig_ref,
    output logic                    valley_trig
);

    typedef struct packed {
        logic below;
        logic trig;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    logic signed [MW-1:0] mod_sig;
    logic                 below_now;

    always_comb begin
        mod_sig   = $signed({{(MW-VW){1'b0}}, vout_code})
                  + {{(MW-OUT_W){ramp_est[OUT_W-1]}}, ramp_est};
        below_now = (mod_sig < trig_ref);
        st_d.below = below_now;
        st_d.trig  = below_now && !st_q.below;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.below <= 1'b1;   // disarmed until the signal sits above the threshold
            st_q.trig  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valley_trig = st_q.trig;

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valley_trig |=> !valley_trig); // R8

endmodule

// File: rtl/cur_ramp_est.sv
module cur_ramp_est
    import cre_pkg::*;
#(
    parameter int VW       = 12,
    parameter int KW       = 16,
    parameter int ACC_W    = 24,
    parameter int OUT_W    = 16,
    parameter int SLOPE_SH = 8,
    parameter int SHW      = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sw_on,
    input  logic                    vin_valid,
    input  logic        [VW-1:0]    vin_code,
    input  logic        [VW-1:0]    vout_code,
    input  logic signed [KW-1:0]    k_gain,
    input  logic        [SHW-1:0]   drift_shift,
    input  logic signed [OUT_W-1:0] valley_ref,
    input  logic signed [OUT_W+1:0] trig_ref,
    output logic signed [OUT_W-1:0] ramp_est,
    output logic                    valley_trig
);

    localparam int PROD_W = KW + VW + 1;
    localparam int SUM_W  = ((PROD_W > ACC_W) ? PROD_W : ACC_W) + 2;
    localparam int MW     = OUT_W + 2;

    logic        [VW-1:0]    vin_held;
    logic signed [SUM_W-1:0] slope;
    logic signed [ACC_W-1:0] acc;
    phase_e                  phase;

    cre_vin_hold #(.VW(VW)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .vin_valid (vin_valid),
        .vin_code  (vin_code),
        .vin_held  (vin_held)
    );

    cre_slope_gen #(
        .VW(VW), .KW(KW), .SLOPE_SH(SLOPE_SH), .SUM_W(SUM_W)
    ) u_slope (
        .vin_held  (vin_held),
        .vout_code (vout_code),
        .k_gain    (k_gain),
        .phase     (phase),
        .slope     (slope)
    );

    cre_accum #(
        .ACC_W(ACC_W), .OUT_W(OUT_W), .SUM_W(SUM_W), .SHW(SHW)
    ) u_acc (
        .clk         (clk),
        .rst         (rst),
        .sw_on       (sw_on),
        .slope       (slope),
        .valley_ref  (valley_ref),
        .drift_shift (drift_shift),
        .phase       (phase),
        .acc         (acc),
        .ramp_est    (ramp_est)
    );

    cre_valley_cmp #(.VW(VW), .OUT_W(OUT_W), .MW(MW)) u_cmp (
        .clk         (clk),
        .rst         (rst),
        .vout_code   (vout_code),
        .ramp_est    (ramp_est),
        .trig_ref    (trig_ref),
        .valley_trig (valley_trig)
    );

    AST_OFF_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (!sw_on && !k_gain[KW-1]) |=> ($signed(ramp_est) <= $past($signed(ramp_est)))); // R4

    AST_ON_NO_FALL: assert property (@(posedge clk) disable iff (rst)
        (sw_on && $past(sw_on) && !k_gain[KW-1] && (vin_held >= vout_code))
        |=> ($signed(acc) >= $past($signed(acc)))); // R3

endmodule

// File: tb/sim_cur_ramp_est.sv
module sim_cur_ramp_est;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sw_on = 1'b0;
    logic               vin_valid = 1'b0;
    logic        [11:0] vin_code = '0;
    logic        [11:0] vout_code = '0;
    logic signed [15:0] k_gain = '0;
    logic        [4:0]  drift_shift = '0;
    logic signed [15:0] valley_ref = 16'sd1000;
    logic signed [17:0] trig_ref = '0;
    logic signed [15:0] ramp_est;
    logic               valley_trig;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    longint m_acc, m_vin;
    bit     m_sw, m_below, m_trig;

    always #(CLK_PERIOD/2) clk = ~clk;

    cur_ramp_est u0 (
        .clk(clk), .rst(rst), .sw_on(sw_on), .vin_valid(vin_valid),
        .vin_code(vin_code), .vout_code(vout_code), .k_gain(k_gain),
        .drift_shift(drift_shift), .valley_ref(valley_ref), .trig_ref(trig_ref),
        .ramp_est(ramp_est), .valley_trig(valley_trig)
    );

    // reference model of one clock edge, from the requirements
    task automatic model_edge();
        longint dv, slope, corr, sum;
        bit below_now;
        if (rst) begin
            m_acc = longint'(valley_ref) * 256;
            m_vin = 0; m_sw = 0; m_below = 1; m_trig = 0;
            return;
        end
        dv    = sw_on ? (m_vin - longint'(vout_code)) : -longint'(vout_code);
        slope = (longint'(k_gain) * dv) >>> 8;
        corr  = (sw_on && !m_sw) ? ((longint'(valley_ref) * 256 - m_acc) >>> drift_shift) : 0;
        sum   = m_acc + slope + corr;
        if (sum > 8388607) sum = 8388607;
        if (sum < -8388608) sum = -8388608;
        below_now = (longint'(vout_code) + (m_acc >>> 8)) < longint'(trig_ref);
        m_trig  = below_now && !m_below;
        m_below = below_now;
        m_acc   = sum;
        if (vin_valid) m_vin = longint'(vin_code);
        m_sw = sw_on;
    endtask

    task automatic check(input string tag);
        n_vec++;
        if (longint'(ramp_est) != (m_acc >>> 8)) begin
            n_fail++;
            $display("FAIL %s/R7 ramp_est actual=%0d expected=%0d", tag, ramp_est, m_acc >>> 8);
        end
        n_vec++;
        if (valley_trig != m_trig) begin
            n_fail++;
            $display("FAIL %s valley_trig actual=%0d expected=%0d", tag, valley_trig, m_trig);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        check(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        step(tag);
        step(tag);
        rst = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        valley_ref = 16'sd1000; trig_ref = -18'sd100000; k_gain = 16'sd256;
        vout_code = 12'd1200; sw_on = 1'b0;
        do_reset("R1");
        n_vec++;
        if (ramp_est != 16'sd1000 || valley_trig != 1'b0) begin
            n_fail++;
            $display("FAIL R1 actual=%0d/%0d expected=1000/0", ramp_est, valley_trig);
        end
    endtask

    // R3 and R4: rising and falling slopes
    task automatic t_ramps();
        vin_code = 12'd3000; vin_valid = 1'b1;
        step("R4");
        vin_valid = 1'b0;
        for (int c = 0; c < 4; c++) begin
            sw_on = 1'b0;
            for (int i = 0; i < 6; i++) step("R4");
            sw_on = 1'b1;
            for (int i = 0; i < 5; i++) step("R3");
        end
        sw_on = 1'b0;
        for (int i = 0; i < 8; i++) begin
            vout_code = 12'(300 + 400 * i);
            step("R4");
        end
    endtask

    // R2: input code held without strobe
    task automatic t_vin_hold();
        sw_on = 1'b0; vout_code = 12'd1000; k_gain = 16'sd512;
        vin_code = 12'd2000; vin_valid = 1'b1;
        step("R2");
        vin_valid = 1'b0; vin_code = 12'd100;
        sw_on = 1'b1;
        for (int i = 0; i < 8; i++) step("R2");
        vin_code = 12'd3500; vin_valid = 1'b1;
        step("R2");
        vin_valid = 1'b0; vin_code = 12'd0;
        for (int i = 0; i < 4; i++) step("R2");
    endtask

    // R5: valley drift correction
    task automatic t_drift();
        valley_ref = 16'sd500; k_gain = 16'sd300; vout_code = 12'd1000;
        for (int c = 0; c < 3; c++) begin
            drift_shift = (c == 0) ? 5'd0 : 5'd2;
            sw_on = 1'b0;
            for (int i = 0; i < 7; i++) step("R5");
            sw_on = 1'b1;
            step("R5");
            step("R5");
        end
        drift_shift = 5'd0; sw_on = 1'b0;
        step("R5");
        sw_on = 1'b1;
        step("R5");
        n_vec++;
        if (longint'(ramp_est) != ((longint'(500) * 256 + ((longint'(300) * (m_vin - 1000)) >>> 8)) >>> 8)) begin
            n_fail++;
            $display("FAIL R5 snap actual=%0d expected=%0d", ramp_est,
                     (longint'(500) * 256 + ((longint'(300) * (m_vin - 1000)) >>> 8)) >>> 8);
        end
    endtask

    // R6: both saturation rails
    task automatic t_sat();
        k_gain = 16'sd32767; vin_code = 12'd4095; vin_valid = 1'b1;
        vout_code = 12'd0; sw_on = 1'b1;
        for (int i = 0; i < 25; i++) step("R6");
        vin_valid = 1'b0;
        n_vec++;
        if (ramp_est != 16'sd32767) begin
            n_fail++;
            $display("FAIL R6 high rail actual=%0d expected=32767", ramp_est);
        end
        sw_on = 1'b0; vout_code = 12'd4095;
        for (int i = 0; i < 40; i++) step("R6");
        n_vec++;
        if (ramp_est != -16'sd32768) begin
            n_fail++;
            $display("FAIL R6 low rail actual=%0d expected=-32768", ramp_est);
        end
    endtask

    // R8 and R9: valley trigger
    task automatic t_trig();
        k_gain = 16'sd0; valley_ref = 16'sd0; trig_ref = 18'sd1000;
        vout_code = 12'd500; sw_on = 1'b0; drift_shift = 5'd0;
        do_reset("R9");
        for (int i = 0; i < 4; i++) step("R9");
        vout_code = 12'd2000;
        step("R8");
        step("R8");
        vout_code = 12'd500;
        for (int i = 0; i < 5; i++) step("R8");
        vout_code = 12'd999;
        step("R8");
        vout_code = 12'd1000;
        step("R8");
        vout_code = 12'd999;
        step("R8");
        step("R8");
        valley_ref = 16'sd200; vout_code = 12'd900; sw_on = 1'b1;
        step("R8");
        step("R8");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        #2;
        t_reset();
        t_ramps();
        t_vin_hold();
        t_drift();
        t_sat();
        do_reset("R1");
        t_trig();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule